// File: doc/BRIEF.md
# NVRAM Bank Image Validator

This block inspects a configuration-memory bank image as it streams past, one byte per beat, each byte tagged with its offset inside the bank. While the bytes flow it collects three things. The first is the signature and the stored header fields. The second is a header checksum folded down to 8 bits. The third is a running two-half checksum modulo 65521 over the body that follows the header's checksum field. When the final byte of the bank has been taken, it pulses `done_o` and presents a verdict together with the generation number and both computed checksums.

A pulse on `start_i` opens a new image, clears every accumulator and samples `seal_i`. With `seal_i` low the block checks an image it has read back. With `seal_i` high it prepares an image for writing. In that case it reports the header checksum and body checksum that the image needs once its signature is forced to the expected value and its generation is bumped by one. The bumped generation is also reported. Bytes must arrive in increasing offset order, and idle cycles between them are allowed.

Top module: `nvram_image_check`

## Requirements
- R1: During and directly after reset, `done_o` and `image_ok_o` are 0, and `generation_o`, `adler_o` and `hdr_sum_o` are all zero.
- R2: In check mode, an image whose byte at offset 0 is not 0x5A is reported invalid (`image_ok_o`=0), with `generation_o`=0.
- R3: `hdr_sum_o` is the sum of byte 0 and bytes 2 to 15, folded by repeatedly adding the upper byte of the sum into its lower byte until the result fits in 8 bits. In check mode, a mismatch with the byte at offset 1 makes the image invalid.
- R4: `adler_o` is {high[15:0], low[15:0]}. It is computed over offsets 0x14 to BANK_BYTES-1, starting from low=1 and high=0. For each byte, low is updated to (low+byte) mod 65521, and then high is updated to (high+low) mod 65521. In check mode, a mismatch with the big-endian word at offsets 16 to 19 makes the image invalid.
- R5: In check mode, when the signature and both checksums all match, `image_ok_o`=1 and `generation_o` equals the big-endian word at offsets 20 to 23.
- R6: `done_o` is low on the clock edge that takes the byte at offset BANK_BYTES-1. It is high for exactly one cycle after the following edge. The results are held after that until the next start.
- R7: In seal mode (`seal_i`=1 at start), `hdr_sum_o` uses 0x5A in place of byte 0. `adler_o` is computed as if offsets 20 to 23 held the stored generation plus one, modulo 2^32. `generation_o` is that incremented value and `image_ok_o` is 0.
- R8: `start_i` clears all results and accumulators: `done_o` and `generation_o` are 0 in the cycle after it. An image restarted part-way through yields the result of the new image only.
- R9: Cycles with `valid_i` low have no effect, whatever `offset_i` and `data_i` hold.
- R10: Both halves of `adler_o` are always below 65521.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new image; clears state and samples seal_i |
| seal_i | input | 1 | Mode for the image: 0 check, 1 seal |
| valid_i | input | 1 | data_i and offset_i carry a byte this cycle |
| offset_i | input | ADDR_W (13) | Byte offset inside the bank |
| data_i | input | 8 | Image byte |
| done_o | output | 1 | One-cycle pulse when the results are ready |
| image_ok_o | output | 1 | Image passed all three checks (check mode only) |
| generation_o | output | 32 | Stored generation, 0 if invalid, or generation+1 in seal mode |
| adler_o | output | 32 | Computed body checksum |
| hdr_sum_o | output | 8 | Computed folded header checksum |

## Verification
The hardest case to reach from the ports is an image that fails exactly one of the three checks while the other two still match. This matters most for a wrong signature, because the header checksum includes the signature byte. The stimulus therefore builds each image in full, seals it with correct checksums, and only then damages one field. For a bad signature, it recomputes the header checksum over the damaged byte so that only the signature comparison fails. The seal path also needs a generation whose increment carries across byte boundaries, and one that wraps from all ones to zero. Both are fed so that the injected generation bytes in the body checksum are exercised.

// File: rtl/nvram_chk_pkg.sv
package nvram_chk_pkg;

  localparam int unsigned ADLER_MOD = 65521;
  localparam logic [7:0]  SIG_VAL   = 8'h5A;

  // header field offsets (the block's decode depends on these)
  localparam int OFF_SIG     = 0;
  localparam int OFF_HCK     = 1;
  localparam int OFF_HSUM_LO = 2;
  localparam int OFF_HSUM_HI = 15;
  localparam int OFF_ADL_LO  = 16;
  localparam int OFF_ADL_HI  = 19;
  localparam int OFF_GEN_LO  = 20;
  localparam int OFF_GEN_HI  = 23;
  localparam int HDR_SPAN    = 32;

  localparam int HSUM_TERMS  = OFF_HSUM_HI - OFF_HSUM_LO + 2;
  localparam int HSUM_MAX    = HSUM_TERMS * 255;

  function automatic logic [15:0] mod_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 17'(ADLER_MOD)) s = s - 17'(ADLER_MOD);
    return s[15:0];
  endfunction

  // two end-around folds bring any 16-bit value into 8 bits
  function automatic logic [7:0] fold8(input logic [15:0] s);
    logic [15:0] t;
    t = s;
    for (int k = 0; k < 2; k++) t = {8'h00, t[7:0]} + {8'h00, t[15:8]};
    return t[7:0];
  endfunction

  // checksum halves after the four generation bytes, from low=1 high=0
  function automatic logic [15:0] gen_low(input logic [31:0] g);
    return 16'd1 + 16'(g[31:24]) + 16'(g[23:16]) + 16'(g[15:8]) + 16'(g[7:0]);
  endfunction

  function automatic logic [15:0] gen_high(input logic [31:0] g);
    return 16'd4 + 16'd4 * 16'(g[31:24]) + 16'd3 * 16'(g[23:16])
         + 16'd2 * 16'(g[15:8]) + 16'(g[7:0]);
  endfunction

endpackage

// File: rtl/nvram_hdr_sum.sv
module nvram_hdr_sum
  import nvram_chk_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              beat_i,
  input  logic              seal_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [7:0]        byte_i,
  output logic [7:0]        sum_o
);

  logic [15:0] acc_q;
  logic        at_sig, in_rng;
  logic [7:0]  term;

  assign at_sig = off_i == ADDR_W'(OFF_SIG);
  assign in_rng = (off_i >= ADDR_W'(OFF_HSUM_LO)) && (off_i <= ADDR_W'(OFF_HSUM_HI));
  assign term   = (at_sig && seal_i) ? SIG_VAL : byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          acc_q <= '0;
    else if (clr_i)                       acc_q <= '0;
    else if (beat_i && (at_sig || in_rng)) acc_q <= acc_q + {8'h00, term};
  end

  assign sum_o = fold8(acc_q);

  // R3: ordered input never lets the raw sum exceed its term budget
  a_r3_acc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= 16'(HSUM_MAX));

endmodule

// File: rtl/nvram_adler_acc.sv
module nvram_adler_acc
  import nvram_chk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        add_i,
  input  logic        inject_i,
  input  logic [7:0]  byte_i,
  input  logic [31:0] gen_i,
  output logic [31:0] sum_o
);

  logic [15:0] low_q, high_q, low_n;

  assign low_n = mod_add(low_q, {8'h00, byte_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= 16'd1;
      high_q <= '0;
    end else if (clr_i) begin
      low_q  <= 16'd1;
      high_q <= '0;
    end else if (inject_i) begin
      // generation bytes folded in at once, in closed form
      low_q  <= gen_low(gen_i);
      high_q <= gen_high(gen_i);
    end else if (add_i) begin
      low_q  <= low_n;
      high_q <= mod_add(high_q, low_n);
    end
  end

  assign sum_o = {high_q, low_q};

  a_r10_low_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_q < 16'(ADLER_MOD));
  a_r10_high_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_q < 16'(ADLER_MOD));

endmodule

// File: rtl/nvram_field_cap.sv
module nvram_field_cap
  import nvram_chk_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              beat_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [7:0]        byte_i,
  output logic [7:0]        sig_o,
  output logic [7:0]        hck_o,
  output logic [31:0]       adl_o,
  output logic [31:0]       gen_o
);

  logic in_adl, in_gen;

  assign in_adl = (off_i >= ADDR_W'(OFF_ADL_LO)) && (off_i <= ADDR_W'(OFF_ADL_HI));
  assign in_gen = (off_i >= ADDR_W'(OFF_GEN_LO)) && (off_i <= ADDR_W'(OFF_GEN_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_o <= '0;
      hck_o <= '0;
      adl_o <= '0;
      gen_o <= '0;
    end else if (clr_i) begin
      sig_o <= '0;
      hck_o <= '0;
      adl_o <= '0;
      gen_o <= '0;
    end else if (beat_i) begin
      if (off_i == ADDR_W'(OFF_SIG)) sig_o <= byte_i;
      if (off_i == ADDR_W'(OFF_HCK)) hck_o <= byte_i;
      if (in_adl) adl_o <= {adl_o[23:0], byte_i};  // big-endian shift-in
      if (in_gen) gen_o <= {gen_o[23:0], byte_i};
    end
  end

endmodule

// File: rtl/nvram_image_check.sv
module nvram_image_check
  import nvram_chk_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  localparam int ADDR_W    = $clog2(BANK_BYTES),
  localparam int LAST_OFF  = BANK_BYTES - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              seal_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [7:0]        data_i,
  output logic              done_o,
  output logic              image_ok_o,
  output logic [31:0]       generation_o,
  output logic [31:0]       adler_o,
  output logic [7:0]        hdr_sum_o
);

  logic        beat, inject, add, seal_q, fin_q, chk_ok;
  logic [7:0]  sig_st, hck_st, hsum;
  logic [31:0] adl_st, gen_st, adl_sum, gen_stream, gen_inj, gen_res;

  assign beat   = valid_i && !start_i;
  assign inject = beat && (offset_i == ADDR_W'(OFF_GEN_HI));
  assign add    = beat && (offset_i > ADDR_W'(OFF_GEN_HI));

  assign gen_stream = {gen_st[23:0], data_i};
  assign gen_inj    = seal_q ? gen_stream + 32'd1 : gen_stream;

  nvram_field_cap #(.ADDR_W(ADDR_W)) u_fields (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(start_i), .beat_i(beat),
    .off_i (offset_i), .byte_i(data_i),
    .sig_o (sig_st), .hck_o(hck_st), .adl_o(adl_st), .gen_o(gen_st)
  );

  nvram_hdr_sum #(.ADDR_W(ADDR_W)) u_hsum (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(start_i), .beat_i(beat),
    .seal_i(seal_q), .off_i(offset_i), .byte_i(data_i), .sum_o(hsum)
  );

  nvram_adler_acc u_adler (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(start_i), .add_i(add),
    .inject_i(inject), .byte_i(data_i), .gen_i(gen_inj), .sum_o(adl_sum)
  );

  assign chk_ok  = !seal_q && (sig_st == SIG_VAL) && (hck_st == hsum) && (adl_st == adl_sum);
  assign gen_res = seal_q ? gen_st + 32'd1 : (chk_ok ? gen_st : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seal_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (start_i) seal_q <= seal_i;
      fin_q <= beat && (offset_i == ADDR_W'(LAST_OFF));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      image_ok_o   <= 1'b0;
      generation_o <= '0;
      adler_o      <= '0;
      hdr_sum_o    <= '0;
    end else if (start_i) begin
      done_o       <= 1'b0;
      image_ok_o   <= 1'b0;
      generation_o <= '0;
      adler_o      <= '0;
      hdr_sum_o    <= '0;
    end else if (fin_q) begin
      done_o       <= 1'b1;
      image_ok_o   <= chk_ok;
      generation_o <= gen_res;
      adler_o      <= adl_sum;
      hdr_sum_o    <= hsum;
    end else begin
      done_o       <= 1'b0;
    end
  end

  // R6: done follows the final byte by two edges
  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && !start_i && offset_i == ADDR_W'(LAST_OFF), 2));
  a_r8_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && generation_o == '0));
  a_r7_seal_never_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seal_q) |-> !image_ok_o);
  a_r5_invalid_gen_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !seal_q && !image_ok_o) |-> generation_o == '0);
  a_r2_ok_needs_sig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && image_ok_o) |-> sig_st == SIG_VAL);

endmodule

// File: tb/nvram_image_check_test.sv
`timescale 1ns/1ps
module nvram_image_check_test;

  localparam int NB = 8192;

  typedef struct packed {
    logic [31:0] seed;
    logic [31:0] gen;
    logic [2:0]  corrupt;  // 0 none, 1 signature, 2 hdr cksum byte, 3 body byte, 4 erased
    logic        seal;
    logic        gap;
    logic        ok;
  } vec_t;

  localparam vec_t VECS [7] = '{
    {32'd3,   32'h0000_0005, 3'd0, 1'b0, 1'b0, 1'b1},
    {32'd77,  32'h1234_5678, 3'd1, 1'b0, 1'b0, 1'b0},
    {32'd9,   32'h0000_00A0, 3'd2, 1'b0, 1'b0, 1'b0},
    {32'd200, 32'h0000_002A, 3'd3, 1'b0, 1'b0, 1'b0},
    {32'd5,   32'h00FF_FFFF, 3'd0, 1'b1, 1'b1, 1'b0},
    {32'd11,  32'hDEAD_BEEF, 3'd0, 1'b0, 1'b1, 1'b1},
    {32'd1,   32'h0000_0001, 3'd4, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n, start, seal, valid;
  logic [12:0] offset;
  logic [7:0]  data;
  logic        done, ok;
  logic [31:0] gen, adl;
  logic [7:0]  hs;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [7:0] hdr_b [32];
  int  seed_g;
  bit  erased, flip;

  always #5 clk = ~clk;

  nvram_image_check uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seal_i(seal), .valid_i(valid),
    .offset_i(offset), .data_i(data), .done_o(done), .image_ok_o(ok),
    .generation_o(gen), .adler_o(adl), .hdr_sum_o(hs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] get_byte(input int i);
    logic [7:0] b;
    int t;
    if (erased) return 8'hFF;
    if (i < 32) return hdr_b[i];
    t = (i * seed_g) ^ (i >> 3) ^ seed_g;
    b = 8'(t);
    if (flip && i == NB - 1) b = b ^ 8'h10;
    return b;
  endfunction

  function automatic logic [7:0] calc_hs(input logic [7:0] sig_b);
    int s = int'(sig_b);
    for (int i = 2; i <= 15; i++) s += int'(get_byte(i));
    while (s > 255) s = (s & 255) + (s >> 8);
    return 8'(s);
  endfunction

  function automatic logic [31:0] calc_adler(input bit use_ov, input logic [31:0] ov);
    longint lo = 1, hi = 0;
    logic [7:0] b;
    for (int i = 20; i < NB; i++) begin
      b = (use_ov && i < 24) ? ov[8*(23-i) +: 8] : get_byte(i);
      lo += longint'(b);
      hi += lo;
    end
    lo = lo % 65521;
    hi = hi % 65521;
    return {hi[15:0], lo[15:0]};
  endfunction

  function automatic logic [31:0] stored_gen();
    return {get_byte(20), get_byte(21), get_byte(22), get_byte(23)};
  endfunction

  task automatic build(input int sd, input logic [31:0] g);
    logic [31:0] a;
    erased = 0; flip = 0; seed_g = sd;
    for (int i = 0; i < 32; i++) hdr_b[i] = 8'h00;
    hdr_b[0] = 8'h5A;
    hdr_b[3] = 8'h20;
    for (int i = 4; i < 16; i++) hdr_b[i] = 8'(8'h41 + i + sd);
    for (int i = 0; i < 4; i++) hdr_b[20+i] = g[8*(3-i) +: 8];
    a = calc_adler(0, 32'h0);
    for (int i = 0; i < 4; i++) hdr_b[16+i] = a[8*(3-i) +: 8];
    hdr_b[1] = calc_hs(hdr_b[0]);
  endtask

  task automatic feed(input logic sl, input logic gp, input int count);
    @(negedge clk); start = 1; seal = sl; valid = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < count; i++) begin
      valid = 1; offset = 13'(i); data = get_byte(i);
      @(negedge clk);
      if (gp && (i % 7 == 3)) begin
        // R9: idle beat carrying the final offset and junk data
        valid = 0; offset = 13'h1FFF; data = 8'hC3;
        @(negedge clk);
      end
    end
    valid = 0;
  endtask

  task automatic verify(input logic sl, input logic exp_ok, input string tag);
    logic [31:0] e_gen, e_adl;
    logic [7:0]  e_hs;
    if (sl) begin
      e_gen = stored_gen() + 32'd1;
      e_hs  = calc_hs(8'h5A);
      e_adl = calc_adler(1, e_gen);
    end else begin
      e_gen = exp_ok ? stored_gen() : 32'h0;
      e_hs  = calc_hs(get_byte(0));
      e_adl = calc_adler(0, 32'h0);
    end
    chk("R6 done not yet", 32'(done), 32'd0);
    @(negedge clk);
    chk("R6 done pulse", 32'(done), 32'd1);
    chk({tag, " ok flag"}, 32'(ok), 32'(exp_ok));
    chk({tag, " generation"}, gen, e_gen);
    chk(sl ? "R7 sealed adler" : "R4 adler", adl, e_adl);
    chk(sl ? "R7 sealed hdr sum" : "R3 hdr sum", 32'(hs), 32'(e_hs));
    chk("R10 low half", 32'(adl[15:0] < 16'd65521), 32'd1);
    chk("R10 high half", 32'(adl[31:16] < 16'd65521), 32'd1);
    @(negedge clk);
    chk("R6 done drops", 32'(done), 32'd0);
    chk("R6 results held", gen, e_gen);
  endtask

  function automatic string row_tag(input vec_t v);
    if (v.seal) return "R7";
    case (v.corrupt)
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R2";
      default: return v.gap ? "R9" : "R5";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; seal = 0; valid = 0; offset = '0; data = '0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 gen in reset", gen, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ok after reset", 32'(ok), 32'd0);
    chk("R1 adler after reset", adl, 32'h0);
    chk("R1 hdr sum after reset", 32'(hs), 32'd0);

    for (int v = 0; v < 7; v++) begin
      build(int'(VECS[v].seed), VECS[v].gen);
      case (VECS[v].corrupt)
        3'd1: begin hdr_b[0] = 8'h5B; hdr_b[1] = calc_hs(8'h5B); end
        3'd2: hdr_b[1] = hdr_b[1] ^ 8'h01;
        3'd3: flip = 1;
        3'd4: erased = 1;
        default: ;
      endcase
      feed(VECS[v].seal, VECS[v].gap, NB);
      verify(VECS[v].seal, VECS[v].ok, row_tag(VECS[v]));
    end

    // R8: abandon an image part-way, then a full one
    build(31, 32'h0000_0077);
    feed(0, 0, 100);
    build(45, 32'h0000_0100);
    feed(0, 0, NB);
    verify(0, 1, "R8");

    // R8: a start alone clears held results
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R8 done cleared", 32'(done), 32'd0);
    chk("R8 gen cleared", gen, 32'h0);
    chk("R8 adler cleared", adl, 32'h0);

    // R7: generation wraps from all ones
    build(8, 32'hFFFF_FFFF);
    feed(1, 0, NB);
    verify(1, 0, "R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule